// File: doc/BRIEF.md
# Vector Length Configuration Unit

This unit carries out the vector-configure operation of a vector-capable core. Each request brings a type word, an application vector length (AVL), and two flags. One flag says the destination register specifier is zero, the other says the source register specifier is zero. The unit then does the following:

- It splits the type word into element width, register-group exponent and the two policy bits.
- It works out the largest vector length that the configured register length allows, using integer shifts only.
- It decides whether the type is legal.
- It chooses the granted vector length from the two zero flags.

One cycle after a request, the unit returns the granted length with a done strobe. In the same cycle it drives a write port toward the vector CSR bank. That port carries the stored type, the new length and a clear of the start index.

Decoding is skipped when the requested type equals the type already stored, and the previously computed maximum is reused. An illegal type is never stored as given. The unit stores instead a sentinel word with only its most significant bit set, and forces both the maximum and the granted length to zero. Out of reset the unit holds that illegal configuration.

Top module: `vcfg_unit`

## Requirements
- R1: After reset the stored type is the sentinel (only bit XLEN-1 set), the length and maximum are 0, the illegal flag is 1, and the done strobe is 0.
- R2: A request sampled with `cfg_valid` high at a rising edge gives `cfg_done`, `csr_wr_en` and `csr_vstart_clr` high for exactly the following cycle. None of them is high without a request.
- R3: Element width is 8 << type[5:3]. type[2:0] is a two's-complement group exponent e. The maximum length is (VLEN / width) << e for e >= 0, and (VLEN / width) >> -e for e < 0.
- R4: type[6] is reported on `tail_agn` and type[7] on `mask_agn` after the request. Both read 0 after an illegal request.
- R5: A type is illegal in any of three cases. Case 1: e = -4 (type[2:0] = 3'b100). Case 2: the width exceeds ELEN for e >= 0, or exceeds ELEN >> -e for e < 0. Case 3: any bit from 8 upward is set. An illegal type stores the sentinel, gives a maximum of 0 and a length of 0, and raises `type_ill`.
- R6: When the source is nonzero, the new length is min(AVL, maximum), comparing the full XLEN-wide AVL.
- R7: When the destination is nonzero and the source is zero, the new length equals the maximum.
- R8: When both specifiers are zero, the new length is the current length clamped to the maximum.
- R9: A request whose type equals the stored type reuses the stored maximum and policy bits and gives the same result as a fresh decode.
- R10: The returned length `cfg_vl` equals the length written on `csr_vl_wdata`, and both reflect the request completed in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_valid | input | 1 | Configure request strobe |
| cfg_type | input | XLEN | Requested type word |
| cfg_avl | input | XLEN | Requested application vector length |
| dst_zero | input | 1 | Destination specifier is zero |
| src_zero | input | 1 | Source specifier is zero |
| cfg_done | output | 1 | Result valid, one cycle after the request |
| cfg_vl | output | VL_W | Granted vector length returned to the requester |
| csr_wr_en | output | 1 | CSR bank write enable for type and length |
| csr_type_wdata | output | XLEN | Type value stored in the CSR bank |
| csr_vl_wdata | output | VL_W | Length value stored in the CSR bank |
| csr_vstart_clr | output | 1 | Clears the start index in the CSR bank |
| max_vl | output | VL_W | Maximum length of the current configuration |
| tail_agn | output | 1 | Tail-agnostic policy of the current type |
| mask_agn | output | 1 | Mask-agnostic policy of the current type |
| type_ill | output | 1 | Current configuration is illegal |

## Verification
The properties take for granted that `cfg_type`, `cfg_avl` and both zero flags are known and steady while `cfg_valid` is high around the sampling edge. They also assume that requests are single-cycle pulses or back-to-back runs, with no outstanding handshake. The stimulus changes every input only on the falling edge and keeps `cfg_valid` low during reset. It mixes isolated requests with back-to-back pairs that repeat the same type, so that both the decode path and the reuse path are reached.

// File: rtl/vcfg_pkg.sv
package vcfg_pkg;

  // Width in bits selected by the three width bits of the type word.
  function automatic int unsigned elem_width(input logic [2:0] wcode);
    elem_width = 32'd8 << wcode;
  endfunction

  // Magnitude of a negative group exponent (only meaningful when bit 2 set).
  function automatic logic [2:0] frac_shift(input logic [2:0] gcode);
    frac_shift = 3'd0 - gcode;
  endfunction

  // Group factor must lie between 1/8 and 8; exponent -4 falls outside.
  function automatic logic group_in_range(input logic [2:0] gcode);
    group_in_range = (gcode != 3'b100);
  endfunction

  // Element width must fit in ELEN scaled by min(group, 1).
  function automatic logic width_fits(input int unsigned elen,
                                      input logic [2:0]  wcode,
                                      input logic [2:0]  gcode);
    int unsigned w;
    w = elem_width(wcode);
    if (gcode[2])
      width_fits = ((w << frac_shift(gcode)) <= elen);
    else
      width_fits = (w <= elen);
  endfunction

  // Maximum length with integer shifts only.
  function automatic int unsigned calc_vlmax(input int unsigned vlen,
                                             input logic [2:0]  wcode,
                                             input logic [2:0]  gcode);
    int unsigned per_reg;
    per_reg = vlen >> (32'(wcode) + 32'd3);
    if (gcode[2])
      calc_vlmax = per_reg >> frac_shift(gcode);
    else
      calc_vlmax = per_reg << gcode[1:0];
  endfunction

endpackage

// File: rtl/vcfg_type_decode.sv
module vcfg_type_decode #(
  parameter int XLEN = 64,
  parameter int VLEN = 128,
  parameter int ELEN = 64,
  parameter int VL_W = 8
) (
  input  logic [XLEN-1:0] req_type,
  output logic            illegal,
  output logic [VL_W-1:0] vlmax,
  output logic            tail_ag,
  output logic            mask_ag
);
  logic [2:0] wcode;
  logic [2:0] gcode;
  logic       upper_nz;
  logic       grp_ok;
  logic       wid_ok;

  assign wcode    = req_type[5:3];
  assign gcode    = req_type[2:0];
  assign upper_nz = |req_type[XLEN-1:8];
  assign grp_ok   = vcfg_pkg::group_in_range(gcode);
  assign wid_ok   = vcfg_pkg::width_fits(ELEN, wcode, gcode);

  always_comb begin
    illegal = upper_nz | ~grp_ok | ~wid_ok;
    if (illegal) begin
      vlmax   = '0;
      tail_ag = 1'b0;
      mask_ag = 1'b0;
    end else begin
      vlmax   = VL_W'(vcfg_pkg::calc_vlmax(VLEN, wcode, gcode));
      tail_ag = req_type[6];
      mask_ag = req_type[7];
    end
  end
endmodule

// File: rtl/vcfg_len_select.sv
module vcfg_len_select #(
  parameter int XLEN = 64,
  parameter int VL_W = 8
) (
  input  logic [VL_W-1:0] vlmax,
  input  logic [VL_W-1:0] cur_vl,
  input  logic [XLEN-1:0] avl,
  input  logic            dst_zero,
  input  logic            src_zero,
  output logic [VL_W-1:0] new_vl
);
  logic avl_over;
  logic cur_over;

  assign avl_over = (avl > XLEN'(vlmax));
  assign cur_over = (cur_vl > vlmax);

  always_comb begin
    if (vlmax == '0)
      new_vl = '0;
    else if (!src_zero)
      new_vl = avl_over ? vlmax : avl[VL_W-1:0];
    else if (!dst_zero)
      new_vl = vlmax;
    else
      new_vl = cur_over ? vlmax : cur_vl;
  end
endmodule

// File: rtl/vcfg_unit.sv
module vcfg_unit #(
  parameter int XLEN = 64,
  parameter int VLEN = 128,
  parameter int ELEN = 64,
  localparam int VL_W = $clog2(VLEN) + 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_valid,
  input  logic [XLEN-1:0] cfg_type,
  input  logic [XLEN-1:0] cfg_avl,
  input  logic            dst_zero,
  input  logic            src_zero,
  output logic            cfg_done,
  output logic [VL_W-1:0] cfg_vl,
  output logic            csr_wr_en,
  output logic [XLEN-1:0] csr_type_wdata,
  output logic [VL_W-1:0] csr_vl_wdata,
  output logic            csr_vstart_clr,
  output logic [VL_W-1:0] max_vl,
  output logic            tail_agn,
  output logic            mask_agn,
  output logic            type_ill
);
  localparam logic [XLEN-1:0] ILL_TYPE = {1'b1, {(XLEN-1){1'b0}}};

  logic [XLEN-1:0] type_q;
  logic [VL_W-1:0] vl_q, vlmax_q;
  logic            ta_q, ma_q, ill_q, done_q;

  logic            dec_ill, dec_ta, dec_ma;
  logic [VL_W-1:0] dec_vlmax;

  // Named internal events for the checker
  logic            type_changed;
  logic            eff_ill, eff_ta, eff_ma;
  logic [VL_W-1:0] eff_vlmax;
  logic [VL_W-1:0] sel_vl;
  logic [XLEN-1:0] next_type;

  vcfg_type_decode #(.XLEN(XLEN), .VLEN(VLEN), .ELEN(ELEN), .VL_W(VL_W)) dec_i (
    .req_type (cfg_type),
    .illegal  (dec_ill),
    .vlmax    (dec_vlmax),
    .tail_ag  (dec_ta),
    .mask_ag  (dec_ma)
  );

  assign type_changed = (cfg_type != type_q);

  always_comb begin
    if (type_changed) begin
      eff_ill   = dec_ill;
      eff_ta    = dec_ta;
      eff_ma    = dec_ma;
      eff_vlmax = dec_vlmax;
      next_type = dec_ill ? ILL_TYPE : cfg_type;
    end else begin
      eff_ill   = ill_q;
      eff_ta    = ta_q;
      eff_ma    = ma_q;
      eff_vlmax = vlmax_q;
      next_type = type_q;
    end
  end

  vcfg_len_select #(.XLEN(XLEN), .VL_W(VL_W)) sel_i (
    .vlmax    (eff_vlmax),
    .cur_vl   (vl_q),
    .avl      (cfg_avl),
    .dst_zero (dst_zero),
    .src_zero (src_zero),
    .new_vl   (sel_vl)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      type_q  <= ILL_TYPE;
      vl_q    <= '0;
      vlmax_q <= '0;
      ta_q    <= 1'b0;
      ma_q    <= 1'b0;
      ill_q   <= 1'b1;
      done_q  <= 1'b0;
    end else begin
      done_q <= cfg_valid;
      if (cfg_valid) begin
        type_q  <= next_type;
        vl_q    <= sel_vl;
        vlmax_q <= eff_vlmax;
        ta_q    <= eff_ta;
        ma_q    <= eff_ma;
        ill_q   <= eff_ill;
      end
    end
  end

  assign cfg_done       = done_q;
  assign cfg_vl         = vl_q;
  assign csr_wr_en      = done_q;
  assign csr_vstart_clr = done_q;
  assign csr_type_wdata = type_q;
  assign csr_vl_wdata   = vl_q;
  assign max_vl         = vlmax_q;
  assign tail_agn       = ta_q;
  assign mask_agn       = ma_q;
  assign type_ill       = ill_q;
endmodule

// File: rtl/vcfg_unit_chk.sv
module vcfg_unit_chk #(
  parameter int XLEN = 64,
  parameter int VL_W = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cfg_valid,
  input logic            dst_zero,
  input logic            src_zero,
  input logic            type_changed,
  input logic            cfg_done,
  input logic [XLEN-1:0] csr_type_wdata,
  input logic [VL_W-1:0] csr_vl_wdata,
  input logic [VL_W-1:0] max_vl,
  input logic            type_ill
);
  localparam logic [XLEN-1:0] SENT = {1'b1, {(XLEN-1){1'b0}}};

  AST_DONE_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_valid |=> cfg_done); // R2
  AST_NO_IDLE_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_valid |=> !cfg_done); // R2
  AST_VL_WITHIN_MAX: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_done |-> csr_vl_wdata <= max_vl); // R6
  AST_ILL_SENTINEL: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_done && type_ill) |-> (csr_type_wdata == SENT && csr_vl_wdata == '0 && max_vl == '0)); // R5
  AST_DST_ONLY_MAX: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_valid && !dst_zero && src_zero) |=> (csr_vl_wdata == max_vl)); // R7
  AST_KEEP_NO_GROW: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_valid && dst_zero && src_zero && !type_changed) |=> (csr_vl_wdata <= $past(csr_vl_wdata))); // R8
  AST_REUSE_MAX: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_valid && !type_changed) |=> $stable(max_vl)); // R9
endmodule

bind vcfg_unit vcfg_unit_chk #(.XLEN(XLEN), .VL_W(VL_W)) chk_i (
  .clk            (clk),
  .rst_n          (rst_n),
  .cfg_valid      (cfg_valid),
  .dst_zero       (dst_zero),
  .src_zero       (src_zero),
  .type_changed   (type_changed),
  .cfg_done       (cfg_done),
  .csr_type_wdata (csr_type_wdata),
  .csr_vl_wdata   (csr_vl_wdata),
  .max_vl         (max_vl),
  .type_ill       (type_ill)
);

// File: tb/vcfg_unit_tb_top.sv
module vcfg_unit_tb_top;
  localparam int XLEN = 64;
  localparam int VLEN = 128;
  localparam int ELEN = 64;
  localparam int VL_W = $clog2(VLEN) + 1;
  localparam logic [XLEN-1:0] SENT = {1'b1, {(XLEN-1){1'b0}}};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_valid = 1'b0;
  logic [XLEN-1:0] cfg_type = '0;
  logic [XLEN-1:0] cfg_avl = '0;
  logic dst_zero = 1'b1;
  logic src_zero = 1'b1;
  logic cfg_done, csr_wr_en, csr_vstart_clr, tail_agn, mask_agn, type_ill;
  logic [VL_W-1:0] cfg_vl, csr_vl_wdata, max_vl;
  logic [XLEN-1:0] csr_type_wdata;

  always #4 clk = ~clk;

  vcfg_unit #(.XLEN(XLEN), .VLEN(VLEN), .ELEN(ELEN)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .cfg_type(cfg_type),
    .cfg_avl(cfg_avl), .dst_zero(dst_zero), .src_zero(src_zero),
    .cfg_done(cfg_done), .cfg_vl(cfg_vl), .csr_wr_en(csr_wr_en),
    .csr_type_wdata(csr_type_wdata), .csr_vl_wdata(csr_vl_wdata),
    .csr_vstart_clr(csr_vstart_clr), .max_vl(max_vl), .tail_agn(tail_agn),
    .mask_agn(mask_agn), .type_ill(type_ill)
  );

  typedef struct {
    longint unsigned typ;
    int vl;
    int vmax;
    bit ta;
    bit ma;
    bit ill;
    string tag;
  } exp_t;

  exp_t sb_q[$];
  int n_checks = 0;
  int n_fail = 0;
  int m_vl = 0;
  bit finished = 0;

  task automatic chk(input longint unsigned act, input longint unsigned expv, input string req, input string what);
    n_checks++;
    if (act != expv) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, expv);
    end
  endtask

  // Reference: plain multiply/divide arithmetic, decoded afresh every time.
  function automatic exp_t model(input longint unsigned t, input longint unsigned avl,
                                 input bit dz, input bit sz, input int cur, input string tag);
    exp_t r;
    int w, e, f;
    bit legal;
    w = 8 * (1 << int'(t[5:3]));
    e = int'($signed(t[2:0]));
    f = (e < 0) ? (1 << (-e)) : 1;
    legal = ((t >> 8) == 0) && (e != -4) && ((e >= 0) ? (w <= ELEN) : (w * f <= ELEN));
    r.tag = tag;
    if (!legal) begin
      r.typ = SENT; r.vmax = 0; r.ta = 0; r.ma = 0; r.ill = 1;
    end else begin
      r.typ = t; r.ill = 0; r.ta = t[6]; r.ma = t[7];
      r.vmax = (e >= 0) ? (VLEN / w) * (1 << e) : VLEN / (w * f);
    end
    if (r.vmax == 0) r.vl = 0;
    else if (!sz) r.vl = (avl > longint'(r.vmax)) ? r.vmax : int'(avl);
    else if (!dz) r.vl = r.vmax;
    else r.vl = (cur > r.vmax) ? r.vmax : cur;
    return r;
  endfunction

  task automatic drive(input longint unsigned t, input longint unsigned avl,
                       input bit dz, input bit sz, input string tag);
    exp_t e;
    @(negedge clk);
    cfg_valid = 1'b1; cfg_type = t; cfg_avl = avl; dst_zero = dz; src_zero = sz;
    e = model(t, avl, dz, sz, m_vl, tag);
    m_vl = e.vl;
    sb_q.push_back(e);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cfg_valid = 1'b0;
    end
  endtask

  // Monitor: pops one expected item per done strobe.
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (cfg_done) begin
        if (sb_q.size() == 0) begin
          chk(1, 0, "R2", "done without request");
        end else begin
          exp_t e;
          e = sb_q.pop_front();
          chk(csr_vl_wdata, e.vl, e.tag, "csr length");
          chk(cfg_vl, e.vl, "R10", "returned length");
          chk(max_vl, e.vmax, "R3", "maximum length");
          chk(csr_type_wdata, e.typ, "R5", "stored type");
          chk(type_ill, e.ill, "R5", "illegal flag");
          chk({tail_agn, mask_agn}, {e.ta, e.ma}, "R4", "policy bits");
          chk({csr_wr_en, csr_vstart_clr}, 2'b11, "R2", "write and start clear");
        end
      end else begin
        if (csr_wr_en || csr_vstart_clr) chk(1, 0, "R2", "strobe while idle");
      end
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL R2 watchdog: actual hung expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] lfsr;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(csr_type_wdata, SENT, "R1", "reset type");
    chk(cfg_vl, 0, "R1", "reset length");
    chk(max_vl, 0, "R1", "reset maximum");
    chk(type_ill, 1, "R1", "reset illegal");
    chk(cfg_done, 0, "R1", "reset done");

    drive(64'h00, 10, 0, 0, "R6");           // e8 m1: max 16, avl 10
    idle(2);
    drive(64'h00, 100, 0, 0, "R6");          // clamp to 16
    idle(1);
    drive(64'h13, 0, 0, 1, "R7");            // e32 m8: max 32
    drive(64'h0F, 0, 1, 1, "R8");            // e16 mf2: max 4, keep 32 -> 4
    drive(64'h0F, 0, 1, 1, "R9");            // same type reused
    idle(1);
    drive(64'hC8, 5, 0, 0, "R4");            // ta=ma=1, e16 m1 max 8
    drive(64'hC8, 64'hFFFF_FFFF_FFFF_FFFF, 1, 0, "R6"); // huge avl, reuse path
    drive(64'h100, 7, 0, 0, "R5");           // upper bit
    drive(64'h04, 7, 0, 0, "R5");            // group exponent -4
    drive(64'h1F, 7, 0, 1, "R5");            // e64 mf2 too wide
    drive(64'h20, 7, 1, 1, "R5");            // width code 4
    drive(64'h05, 9, 0, 0, "R6");            // e8 mf8: max 2
    drive(64'h05, 0, 0, 0, "R6");            // avl 0
    drive(64'h03, 0, 1, 1, "R8");            // e8 m8 max 128, keep 0
    drive(SENT, 3, 0, 0, "R5");              // sentinel requested directly
    idle(2);
    lfsr = 32'hACE1_2345;
    for (int i = 0; i < 60; i++) begin
      longint unsigned t;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      t = {55'd0, lfsr[8] & lfsr[9], lfsr[7:0]};
      drive(t, {56'd0, lfsr[23:16]}, lfsr[24], lfsr[25], lfsr[25] ? "R8" : "R6");
      if (lfsr[26]) idle(1);
    end
    idle(3);
    chk(sb_q.size(), 0, "R2", "pending results");
    finish_run();
  end
endmodule